// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Front-End

This block is the digital half of a two-channel, serially loaded digital-to-analog converter. A host writes 24-bit command words over a three-wire link: a serial clock, an active-low frame select and a data line. Each complete word is decoded into a write to a per-channel staging (input) register, and optionally into the channel's output (DAC) register. The two DAC register values leave the block as parallel words for the converter core. All serial and control pins are treated as asynchronous and oversampled by a faster system clock, so every edge is detected inside a single clock domain.

Two update styles are supported. With the load pin held low, a staging write also moves the addressed output register at the end of the frame. With the load pin held high, staging writes only fill the input registers, and a later falling edge on the load pin moves both channels at once. A falling edge on the clear pin returns every register to the reset code and aborts any frame in flight. A status flag stays high until the next complete frame. The resolution (12, 14 or 16 bits) and the reset code (zero scale or mid-scale) are parameters.

Top module: `duo_dac_front`

## Requirements
- R1: A frame is 24 bits shifted MSB-first from `ser_din` on each falling edge of `ser_clk` while `frame_n` is low. Bits 21:19 hold the command, bits 18:16 the address and bits 15:0 the data; bits 23:22 are ignored.
- R2: A frame takes effect only on its 24th falling `ser_clk` edge. Registers change at no other time except on a clear, a load-pin edge or reset.
- R3: If `frame_n` rises before the 24th falling edge, the partial frame is discarded and no register changes.
- R4: After the 24th edge, further `ser_clk` falling edges are ignored until `frame_n` goes high and then low again.
- R5: A falling edge on `clear_n` loads the reset code into both input registers and both DAC registers, and aborts the frame in progress so its remaining edges commit nothing.
- R6: The reset code is 0 when MIDSCALE=0 and 2^(RES-1) when MIDSCALE=1. It is also the value after `rst_n`.
- R7: `clear_hold` goes high on a clear and returns low on the 24th edge of the next complete frame. It is low after `rst_n`.
- R8: With `load_n` low, command 000 writes the addressed input register and the addressed DAC register together.
- R9: With `load_n` high, command 000 writes only the addressed input register; the DAC outputs do not change.
- R10: A falling edge on `load_n` copies both input registers into both DAC registers in the same cycle.
- R11: Command 011 writes the addressed input register and the addressed DAC register whatever the level of `load_n`.
- R12: Address 000 selects channel A, 001 selects channel B and 111 selects both. Any other address or any other command changes no register.
- R13: The RES-bit value taken is data bits 15 down to 16-RES, so the lower bits are ignored when RES is below 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data taken on falling edges |
| frame_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Update-mode level and simultaneous-load edge |
| clear_n | input | 1 | Falling-edge clear |
| dac_a | output | RES | Channel A DAC register |
| dac_b | output | RES | Channel B DAC register |
| clear_hold | output | 1 | High from a clear until the next complete frame |

## Verification
The bench cuts frames short at 20 and 23 edges. A design that commits on a partial count would show the half-shifted value on an output. It adds eight extra edges after a full frame with the select still low; a counter that does not stop would shift them in and later commit garbage. It pulses the clear pin halfway through a frame and then finishes the clocking. A front-end that only resets registers, without aborting, would still commit that frame and drop the clear flag. It also fires the load edge after the clear to show that the staging registers were cleared too. Staging writes with the load pin high, followed by one load edge, catch a design that leaks staging writes to the outputs or moves only one channel. A 12-bit mid-scale instance beside the default one catches wrong data alignment and a wrong reset code.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   localparam int FRAME_W = 24;
   localparam int NUM_CH  = 2;
   localparam int DAT_W   = 16;

   localparam logic [2:0] CMD_STAGE   = 3'b000;
   localparam logic [2:0] CMD_PUSH    = 3'b011;
   localparam logic [2:0] ADR_BOTH    = 3'b111;

   // frame layout, MSB first on the wire
   typedef struct packed {
      logic [1:0]       spare;
      logic [2:0]       cmd;
      logic [2:0]       adr;
      logic [DAT_W-1:0] dat;
   } frame_t;

   // input vector positions of the synchroniser
   localparam int PIN_SCLK  = 0;
   localparam int PIN_FRAME = 1;
   localparam int PIN_LOAD  = 2;
   localparam int PIN_CLEAR = 3;
   localparam int PIN_DIN   = 4;
   localparam int PIN_CNT   = 5;
   localparam int EDGE_CNT  = 4;

endpackage

// File: rtl/dacfe_in_sync.sv
module dacfe_in_sync #(
   parameter int             W       = 5,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   output logic [W-1:0] level
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dacfe_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
         pipe[0] <= pins;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign level = pipe[STAGES-1];

endmodule

// File: rtl/dacfe_fall_det.sv
module dacfe_fall_det #(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic fall
);

   logic last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= RST_VAL;
      else        last <= level;
   end

   assign fall = last & ~level;

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
   import dacfe_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sclk_fall,
   input  logic   frame_lvl,
   input  logic   frame_fall,
   input  logic   din_lvl,
   input  logic   abort,
   output logic   frame_stb,
   output frame_t frame_word
);

   localparam int CW = $clog2(FRAME_W);
   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_W - 1);

   logic [CW-1:0]      cnt;
   logic               armed;
   logic [FRAME_W-1:0] sh;
   logic [FRAME_W-1:0] sh_nxt;

   assign sh_nxt = {sh[FRAME_W-2:0], din_lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         armed      <= 1'b0;
         sh         <= '0;
         frame_stb  <= 1'b0;
         frame_word <= '0;
      end else begin
         frame_stb <= 1'b0;
         if (abort || frame_lvl) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else if (frame_fall) begin
            cnt   <= '0;
            armed <= 1'b1;
         end else if (sclk_fall && armed) begin
            sh <= sh_nxt;
            if (cnt == LAST_IDX) begin
               cnt        <= '0;
               armed      <= 1'b0;
               frame_stb  <= 1'b1;
               frame_word <= frame_t'(sh_nxt);
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
   import dacfe_pkg::*;
#(
   parameter int RES      = 16,
   parameter bit MIDSCALE = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         frame_stb,
   input  frame_t                       frame_word,
   input  logic                         load_lvl,
   input  logic                         load_fall,
   input  logic                         clr_fall,
   output logic [NUM_CH-1:0][RES-1:0]   in_q,
   output logic [NUM_CH-1:0][RES-1:0]   dac_q,
   output logic                         clear_hold
);

   logic [RES-1:0] rcode;
   logic [RES-1:0] wr_data;
   logic           cmd_ok;
   logic           push_dac;

   generate
      if (MIDSCALE) begin : g_mid
         assign rcode = {1'b1, {(RES-1){1'b0}}};
      end else begin : g_zero
         assign rcode = '0;
      end
   endgenerate

   assign wr_data  = frame_word.dat[DAT_W-1 -: RES];
   assign cmd_ok   = (frame_word.cmd == CMD_STAGE) || (frame_word.cmd == CMD_PUSH);
   assign push_dac = (frame_word.cmd == CMD_PUSH) || !load_lvl;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic           hit;
         logic [RES-1:0] in_nxt;

         assign hit    = frame_stb && cmd_ok &&
                         ((frame_word.adr == 3'(g)) || (frame_word.adr == ADR_BOTH));
         assign in_nxt = hit ? wr_data : in_q[g];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_q[g]  <= rcode;
               dac_q[g] <= rcode;
            end else if (clr_fall) begin
               in_q[g]  <= rcode;
               dac_q[g] <= rcode;
            end else begin
               in_q[g] <= in_nxt;
               if (load_fall)            dac_q[g] <= in_nxt;
               else if (hit && push_dac) dac_q[g] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         clear_hold <= 1'b0;
      else if (clr_fall)  clear_hold <= 1'b1;
      else if (frame_stb) clear_hold <= 1'b0;
   end

endmodule

// File: rtl/duo_dac_front.sv
module duo_dac_front
   import dacfe_pkg::*;
#(
   parameter int RES         = 16,
   parameter bit MIDSCALE    = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           frame_n,
   input  logic           ser_din,
   input  logic           load_n,
   input  logic           clear_n,
   output logic [RES-1:0] dac_a,
   output logic [RES-1:0] dac_b,
   output logic           clear_hold
);

   generate
      if (!(RES == 12 || RES == 14 || RES == 16)) begin : g_bad_res
         $error("duo_dac_front: RES must be 12, 14 or 16");
      end
   endgenerate

   localparam logic [PIN_CNT-1:0] PIN_IDLE = 5'b01111;

   logic [PIN_CNT-1:0]            pins;
   logic [PIN_CNT-1:0]            lvl;
   logic [EDGE_CNT-1:0]           fall;
   logic                          frame_stb;
   frame_t                        frame_word;
   logic [NUM_CH-1:0][RES-1:0]    in_q;
   logic [NUM_CH-1:0][RES-1:0]    dac_q;

   assign pins = {ser_din, clear_n, load_n, frame_n, ser_clk};

   dacfe_in_sync #(
      .W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .pins(pins), .level(lvl)
   );

   generate
      for (genvar e = 0; e < EDGE_CNT; e++) begin : g_edge
         dacfe_fall_det #(.RST_VAL(PIN_IDLE[e])) u_fd (
            .clk(clk), .rst_n(rst_n), .level(lvl[e]), .fall(fall[e])
         );
      end
   endgenerate

   dacfe_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_fall (fall[PIN_SCLK]),
      .frame_lvl (lvl[PIN_FRAME]),
      .frame_fall(fall[PIN_FRAME]),
      .din_lvl   (lvl[PIN_DIN]),
      .abort     (fall[PIN_CLEAR]),
      .frame_stb (frame_stb),
      .frame_word(frame_word)
   );

   dacfe_regs #(.RES(RES), .MIDSCALE(MIDSCALE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .frame_word(frame_word),
      .load_lvl  (lvl[PIN_LOAD]),
      .load_fall (fall[PIN_LOAD]),
      .clr_fall  (fall[PIN_CLEAR]),
      .in_q      (in_q),
      .dac_q     (dac_q),
      .clear_hold(clear_hold)
   );

   assign dac_a = dac_q[0];
   assign dac_b = dac_q[1];

endmodule

// File: rtl/duo_dac_front_chk.sv
module duo_dac_front_chk
   import dacfe_pkg::*;
#(
   parameter int RES      = 16,
   parameter bit MIDSCALE = 1'b0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       frame_stb,
   input frame_t                     frame_word,
   input logic                       load_lvl,
   input logic                       load_fall,
   input logic                       clr_fall,
   input logic [NUM_CH-1:0][RES-1:0] in_q,
   input logic [RES-1:0]             dac_a,
   input logic [RES-1:0]             dac_b,
   input logic                       clear_hold
);

   localparam logic [RES-1:0] RC = MIDSCALE ? {1'b1, {(RES-1){1'b0}}} : '0;

   AST_CLEAR_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fall |=> (dac_a == RC && dac_b == RC && in_q[0] == RC && in_q[1] == RC && clear_hold)); // R5

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && !load_fall && !clr_fall) |=> ($stable(dac_a) && $stable(dac_b) && $stable(in_q))); // R2

   AST_STAGE_NO_DAC: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && load_lvl && frame_word.cmd == CMD_STAGE && !load_fall && !clr_fall)
      |=> ($stable(dac_a) && $stable(dac_b))); // R9

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fall && !clr_fall && !frame_stb)
      |=> (dac_a == $past(in_q[0]) && dac_b == $past(in_q[1]))); // R10

   AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !clr_fall) |=> !clear_hold); // R7

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> !frame_stb); // R4

endmodule

bind duo_dac_front duo_dac_front_chk #(.RES(RES), .MIDSCALE(MIDSCALE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_stb (frame_stb),
   .frame_word(frame_word),
   .load_lvl  (lvl[dacfe_pkg::PIN_LOAD]),
   .load_fall (fall[dacfe_pkg::PIN_LOAD]),
   .clr_fall  (fall[dacfe_pkg::PIN_CLEAR]),
   .in_q      (in_q),
   .dac_a     (dac_a),
   .dac_b     (dac_b),
   .clear_hold(clear_hold)
);

// File: tb/sim_duo_dac_front.sv
`timescale 1ns/1ps
module sim_duo_dac_front;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b1;
   logic frame_n = 1'b1;
   logic ser_din = 1'b0;
   logic load_n = 1'b0;
   logic clear_n = 1'b1;
   logic [15:0] a16, b16;
   logic [11:0] a12, b12;
   logic hold16, hold12;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   duo_dac_front u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n), .ser_din(ser_din),
      .load_n(load_n), .clear_n(clear_n), .dac_a(a16), .dac_b(b16), .clear_hold(hold16)
   );

   duo_dac_front #(.RES(12), .MIDSCALE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n), .ser_din(ser_din),
      .load_n(load_n), .clear_n(clear_n), .dac_a(a12), .dac_b(b12), .clear_hold(hold12)
   );

   function automatic logic [23:0] mk(input logic [2:0] cmd, input logic [2:0] adr,
                                      input logic [15:0] dat);
      return {2'b00, cmd, adr, dat};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [15:0] ea, input logic [15:0] eb,
                          input logic [11:0] ea12, input logic [11:0] eb12);
      chk({req, " u0 dac_a"}, a16, ea);
      chk({req, " u0 dac_b"}, b16, eb);
      chk({req, " u1 dac_a"}, {4'h0, a12}, {4'h0, ea12});
      chk({req, " u1 dac_b"}, {4'h0, b12}, {4'h0, eb12});
   endtask

   task automatic chk_hold(input string req, input logic exp);
      chk({req, " u0 clear_hold"}, {15'h0, hold16}, {15'h0, exp});
      chk({req, " u1 clear_hold"}, {15'h0, hold12}, {15'h0, exp});
   endtask

   task automatic open_frame();
      @(negedge clk); frame_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic close_frame();
      repeat (4) @(negedge clk);
      frame_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic clock_bits(input logic [23:0] w, input int first, input int n);
      for (int i = first; i < first + n; i++) begin
         @(negedge clk);
         ser_din = (i < 24) ? w[23-i] : 1'b1;
         ser_clk = 1'b1;
         repeat (4) @(negedge clk);
         ser_clk = 1'b0;
         repeat (4) @(negedge clk);
      end
      @(negedge clk); ser_clk = 1'b1;
   endtask

   task automatic send(input logic [23:0] w);
      open_frame();
      clock_bits(w, 0, 24);
      close_frame();
   endtask

   task automatic pulse_load();
      @(negedge clk); load_n = 1'b0;
      repeat (6) @(negedge clk);
      load_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      chk_all("R6 reset code", 16'h0000, 16'h0000, 12'h800, 12'h800);
      chk_hold("R7 reset flag", 1'b0);
   endtask

   task automatic t_sync_write();
      load_n = 1'b0;
      send(mk(3'b000, 3'b000, 16'h1234));
      chk_all("R8 R1 R13 sync write A", 16'h1234, 16'h0000, 12'h123, 12'h800);
   endtask

   task automatic t_async_stage();
      @(negedge clk); load_n = 1'b1;
      repeat (6) @(negedge clk);
      send(mk(3'b000, 3'b001, 16'hABCD));
      chk_all("R9 stage B no dac", 16'h1234, 16'h0000, 12'h123, 12'h800);
      send(mk(3'b000, 3'b000, 16'h5555));
      chk_all("R9 stage A no dac", 16'h1234, 16'h0000, 12'h123, 12'h800);
      pulse_load();
      chk_all("R10 load edge both", 16'h5555, 16'hABCD, 12'h555, 12'hABC);
   endtask

   task automatic t_push_cmd();
      send(mk(3'b011, 3'b001, 16'h0F0F));
      chk_all("R11 push B async", 16'h5555, 16'h0F0F, 12'h555, 12'h0F0);
   endtask

   task automatic t_address();
      send(mk(3'b011, 3'b111, 16'h7777));
      chk_all("R12 both channels", 16'h7777, 16'h7777, 12'h777, 12'h777);
      send(mk(3'b011, 3'b010, 16'h1111));
      chk_all("R12 bad address", 16'h7777, 16'h7777, 12'h777, 12'h777);
      send(mk(3'b111, 3'b111, 16'h2222));
      chk_all("R12 bad command", 16'h7777, 16'h7777, 12'h777, 12'h777);
   endtask

   task automatic t_short_frames();
      @(negedge clk); load_n = 1'b0;
      repeat (6) @(negedge clk);
      open_frame();
      clock_bits(mk(3'b011, 3'b000, 16'h2222), 0, 20);
      close_frame();
      chk_all("R3 cut at 20", 16'h7777, 16'h7777, 12'h777, 12'h777);
      open_frame();
      clock_bits(mk(3'b011, 3'b111, 16'h2468), 0, 23);
      close_frame();
      chk_all("R3 cut at 23", 16'h7777, 16'h7777, 12'h777, 12'h777);
   endtask

   task automatic t_extra_edges();
      open_frame();
      clock_bits(mk(3'b000, 3'b000, 16'h3333), 0, 32);
      close_frame();
      chk_all("R4 extra edges", 16'h3333, 16'h7777, 12'h333, 12'h777);
      send(mk(3'b000, 3'b001, 16'h4444));
      chk_all("R4 next frame", 16'h3333, 16'h4444, 12'h333, 12'h444);
   endtask

   task automatic t_clear();
      open_frame();
      clock_bits(mk(3'b011, 3'b111, 16'h6666), 0, 12);
      @(negedge clk); clear_n = 1'b0;
      repeat (6) @(negedge clk);
      clear_n = 1'b1;
      repeat (6) @(negedge clk);
      clock_bits(mk(3'b011, 3'b111, 16'h6666), 12, 12);
      close_frame();
      chk_all("R5 clear aborts", 16'h0000, 16'h0000, 12'h800, 12'h800);
      chk_hold("R7 hold set", 1'b1);
      @(negedge clk); load_n = 1'b1;
      repeat (6) @(negedge clk);
      pulse_load();
      chk_all("R5 inputs cleared", 16'h0000, 16'h0000, 12'h800, 12'h800);
      chk_hold("R7 hold kept", 1'b1);
   endtask

   task automatic t_exit_clear();
      @(negedge clk); load_n = 1'b0;
      repeat (6) @(negedge clk);
      send(mk(3'b000, 3'b000, 16'h9999));
      chk_all("R7 R8 write after clear", 16'h9999, 16'h0000, 12'h999, 12'h800);
      chk_hold("R7 hold exit", 1'b0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_sync_write();
      t_async_stage();
      t_push_cmd();
      t_address();
      t_short_frames();
      t_extra_edges();
      t_clear();
      t_exit_clear();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule